// File: doc/BRIEF.md
# Descriptor Table Fetch and Dispatch Controller

This block runs a batch of transfers whose descriptors sit in a table in host memory. Software first loads three settings through a small 32-bit register port: the 64-bit base of the host-side table and the 32-bit base of the local descriptor store. It then writes the index of the final descriptor, and that write starts the run. The controller asks an external read mover to copy each descriptor, one request per entry, from the host table into a local FIFO. It issues no more requests than the FIFO has free slots.

Descriptors leave the FIFO in index order and go one at a time to a data mover. The controller waits for the mover's completion pulse before it sends the next one. A descriptor whose length is zero is dropped without being sent. When the final descriptor has finished, the controller writes a done word into that descriptor's entry of the host table. After that write is accepted, it raises an interrupt request and returns to idle. A system that has both a read direction and a write direction uses one instance of this block for each.

Top module: `desc_fetch_ctrl`

## Requirements
- R1: After reset the controller is idle: fetchValid, moveValid, wbValid and irqValid are 0, and every register reads 0. The registers are: word 0 table base bits 31:0, word 1 table base bits 63:32, word 2 local store base, word 3 final index in bits 6:0, word 4 busy flag in bit 0.
- R2: Words 0, 1 and 2 read back the value last written to them.
- R3: A write to word 3 while idle stores the final index and starts a run, and the busy flag reads 1 from the next cycle on.
- R4: A run issues exactly one fetch request for each index from 0 up to the final index, in increasing order. Each request has fetchSrc = table base + 32·index, fetchDst = local base + 32·index and fetchLen = 8 dwords.
- R5: The number of descriptors that have been requested but not yet consumed by dispatch never exceeds FIFO_DEPTH. When the data mover is slow, this limit is reached.
- R6: Descriptors are offered to the mover in index order, with fields taken from descInData as {source[152:89], destination[88:25], length in dwords[24:7], index[6:0]}.
- R7: Once a descriptor has been accepted (moveValid and moveReady both high), moveValid stays low until moveDone pulses.
- R8: A descriptor whose length is 0 is never offered to the mover, and it still counts as processed.
- R9: The done write is offered only after the final descriptor is complete: after its moveDone, or at once if it has zero length. wbAddr = table base + 32·final index + 24, and wbData = 1.
- R10: irqValid rises only after the done write has been accepted. Once the interrupt is accepted, the controller returns to idle and the busy flag reads 0.
- R11: A write to word 3 during a run is ignored. The stored final index, the number of fetches and the done address stay those of the running batch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register word index |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for regAddr |
| fetchValid | output | 1 | Descriptor fetch request valid |
| fetchReady | input | 1 | Read mover accepts the fetch |
| fetchSrc | output | 64 | Host address of the descriptor |
| fetchDst | output | 32 | Local store address of the descriptor |
| fetchLen | output | 18 | Fetch length in dwords |
| descInValid | input | 1 | A fetched descriptor is being written into the FIFO |
| descInData | input | 153 | Fetched descriptor fields |
| moveValid | output | 1 | Descriptor offered to the data mover |
| moveReady | input | 1 | Data mover accepts the descriptor |
| moveSrc | output | 64 | Transfer source address |
| moveDst | output | 64 | Transfer destination address |
| moveLen | output | 18 | Transfer length in dwords |
| moveId | output | 7 | Descriptor index field |
| moveDone | input | 1 | One-cycle completion pulse from the data mover |
| wbValid | output | 1 | Done write request valid |
| wbReady | input | 1 | Upstream port accepts the done write |
| wbAddr | output | 64 | Host address of the done word |
| wbData | output | 32 | Done word value |
| irqValid | output | 1 | Interrupt message request |
| irqReady | input | 1 | Interrupt request accepted |

## Verification
The bench builds the controller with FIFO_DEPTH = 4, 32-byte descriptors and the done word at byte offset 24. A six-entry batch against a slow data mover fills the four-slot store, so the fetch limit is reached and its stall can be seen. A table base just below a 4 GiB boundary makes the 64-bit address sum carry into the upper word. A batch whose final index is 127 drives the 7-bit index to its limit and makes the pointers wrap around the four-slot store many times. One batch mixes zero-length entries, including a zero-length final entry, so the done write has to follow a skip instead of a completion pulse.

// File: rtl/desc_fetch_pkg.sv
package desc_fetch_pkg;
  localparam int ADDR_W = 64;
  localparam int LOC_W  = 32;
  localparam int ID_W   = 7;
  localparam int LEN_W  = 18;
  localparam int DESC_W = 2 * ADDR_W + LEN_W + ID_W;
  localparam int RA_W   = 3;

  localparam logic [RA_W-1:0] REG_TBL_LO = 3'd0;
  localparam logic [RA_W-1:0] REG_TBL_HI = 3'd1;
  localparam logic [RA_W-1:0] REG_LOCAL  = 3'd2;
  localparam logic [RA_W-1:0] REG_FINAL  = 3'd3;
  localparam logic [RA_W-1:0] REG_STATUS = 3'd4;

  typedef struct packed {
    logic [ADDR_W-1:0] srcAddr;
    logic [ADDR_W-1:0] dstAddr;
    logic [LEN_W-1:0]  lenDw;
    logic [ID_W-1:0]   descId;
  } descT;

  typedef struct packed {
    logic fetchFire;
    logic popHead;
  } ctlStrobeT;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RUN, ST_WAIT, ST_WRBACK, ST_IRQ
  } ctlStateT;
endpackage

// File: rtl/desc_fetch_dp.sv
module desc_fetch_dp
  import desc_fetch_pkg::*;
#(
  parameter int FIFO_DEPTH = 4,
  parameter int DESC_BYTES = 32,
  parameter int DONE_OFS   = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [RA_W-1:0]   regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  input  logic              busy,
  input  ctlStrobeT         ctl,
  input  logic              descInValid,
  input  logic [DESC_W-1:0] descInData,
  output logic              startReq,
  output logic              fetchPending,
  output logic              fifoEmpty,
  output logic              headZero,
  output logic              headLast,
  output descT              head,
  output logic [ADDR_W-1:0] fetchSrc,
  output logic [LOC_W-1:0]  fetchDst,
  output logic [LEN_W-1:0]  fetchLen,
  output logic [ADDR_W-1:0] wbAddr
);
  localparam int PTR_W      = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1;
  localparam int CNT_W      = ID_W + 1;
  localparam int DESC_SHIFT = $clog2(DESC_BYTES);

  logic [ADDR_W-1:0] tableBase;
  logic [LOC_W-1:0]  localBase;
  logic [ID_W-1:0]   finalId;
  logic [CNT_W-1:0]  fetchIdx, arriveIdx, popIdx;
  descT              fifoMem [FIFO_DEPTH];

  assign startReq = regWrEn && (regAddr == REG_FINAL) && !busy;

  // register file
  always_ff @(posedge clk) begin
    if (!rstN) begin
      tableBase <= '0;
      localBase <= '0;
      finalId   <= '0;
    end else if (regWrEn) begin
      case (regAddr)
        REG_TBL_LO: tableBase[31:0]  <= regWrData;
        REG_TBL_HI: tableBase[63:32] <= regWrData;
        REG_LOCAL:  localBase        <= regWrData;
        REG_FINAL:  if (!busy) finalId <= regWrData[ID_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (regAddr)
      REG_TBL_LO: regRdData = tableBase[31:0];
      REG_TBL_HI: regRdData = tableBase[63:32];
      REG_LOCAL:  regRdData = localBase;
      REG_FINAL:  regRdData = 32'(finalId);
      REG_STATUS: regRdData = {31'd0, busy};
      default:    regRdData = '0;
    endcase
  end

  // run counters: requested, arrived, consumed
  always_ff @(posedge clk) begin
    if (!rstN || startReq) begin
      fetchIdx  <= '0;
      arriveIdx <= '0;
      popIdx    <= '0;
    end else begin
      if (ctl.fetchFire) fetchIdx  <= fetchIdx + 1'b1;
      if (descInValid)   arriveIdx <= arriveIdx + 1'b1;
      if (ctl.popHead)   popIdx    <= popIdx + 1'b1;
    end
  end

  // local descriptor store, indexed by the low counter bits
  always_ff @(posedge clk) begin
    if (descInValid) fifoMem[arriveIdx[PTR_W-1:0]] <= descT'(descInData);
  end

  assign head      = fifoMem[popIdx[PTR_W-1:0]];
  assign fifoEmpty = (arriveIdx == popIdx);
  assign headZero  = (head.lenDw == '0);
  assign headLast  = (popIdx[ID_W-1:0] == finalId);

  assign fetchPending = (fetchIdx <= CNT_W'(finalId)) &&
                        ((fetchIdx - popIdx) < CNT_W'(FIFO_DEPTH));

  assign fetchSrc = tableBase + (ADDR_W'(fetchIdx) << DESC_SHIFT);
  assign fetchDst = localBase + (LOC_W'(fetchIdx) << DESC_SHIFT);
  assign fetchLen = LEN_W'(DESC_BYTES / 4);
  assign wbAddr   = tableBase + (ADDR_W'(finalId) << DESC_SHIFT) + ADDR_W'(DONE_OFS);
endmodule

// File: rtl/desc_fetch_fsm.sv
module desc_fetch_fsm
  import desc_fetch_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      startReq,
  input  logic      fetchPending,
  input  logic      fifoEmpty,
  input  logic      headZero,
  input  logic      headLast,
  input  logic      fetchReady,
  input  logic      moveReady,
  input  logic      moveDone,
  input  logic      wbReady,
  input  logic      irqReady,
  output logic      busy,
  output ctlStrobeT ctl,
  output logic      fetchValid,
  output logic      moveValid,
  output logic      wbValid,
  output logic      irqValid
);
  ctlStateT st, stNext;
  logic     lastQ, lastNext;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st    <= ST_IDLE;
      lastQ <= 1'b0;
    end else begin
      st    <= stNext;
      lastQ <= lastNext;
    end
  end

  assign busy = (st != ST_IDLE);

  always_comb begin
    stNext     = st;
    lastNext   = lastQ;
    ctl        = '0;
    fetchValid = 1'b0;
    moveValid  = 1'b0;
    wbValid    = 1'b0;
    irqValid   = 1'b0;
    case (st)
      ST_IDLE: if (startReq) stNext = ST_RUN;
      ST_RUN, ST_WAIT: begin
        fetchValid    = fetchPending;
        ctl.fetchFire = fetchPending && fetchReady;
        if (st == ST_RUN) begin
          if (!fifoEmpty && headZero) begin
            ctl.popHead = 1'b1;
            if (headLast) stNext = ST_WRBACK;
          end else if (!fifoEmpty) begin
            moveValid = 1'b1;
            if (moveReady) begin
              ctl.popHead = 1'b1;
              lastNext    = headLast;
              stNext      = ST_WAIT;
            end
          end
        end else if (moveDone) begin
          stNext = lastQ ? ST_WRBACK : ST_RUN;
        end
      end
      ST_WRBACK: begin
        wbValid = 1'b1;
        if (wbReady) stNext = ST_IRQ;
      end
      ST_IRQ: begin
        irqValid = 1'b1;
        if (irqReady) stNext = ST_IDLE;
      end
      default: stNext = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/desc_fetch_ctrl.sv
module desc_fetch_ctrl
  import desc_fetch_pkg::*;
#(
  parameter int FIFO_DEPTH = 4,
  parameter int DESC_BYTES = 32,
  parameter int DONE_OFS   = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [RA_W-1:0]   regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  output logic              fetchValid,
  input  logic              fetchReady,
  output logic [ADDR_W-1:0] fetchSrc,
  output logic [LOC_W-1:0]  fetchDst,
  output logic [LEN_W-1:0]  fetchLen,
  input  logic              descInValid,
  input  logic [DESC_W-1:0] descInData,
  output logic              moveValid,
  input  logic              moveReady,
  output logic [ADDR_W-1:0] moveSrc,
  output logic [ADDR_W-1:0] moveDst,
  output logic [LEN_W-1:0]  moveLen,
  output logic [ID_W-1:0]   moveId,
  input  logic              moveDone,
  output logic              wbValid,
  input  logic              wbReady,
  output logic [ADDR_W-1:0] wbAddr,
  output logic [31:0]       wbData,
  output logic              irqValid,
  input  logic              irqReady
);
  ctlStrobeT ctl;
  descT      head;
  logic      busy, startReq, fetchPending, fifoEmpty, headZero, headLast;

  desc_fetch_dp #(
    .FIFO_DEPTH(FIFO_DEPTH), .DESC_BYTES(DESC_BYTES), .DONE_OFS(DONE_OFS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .busy(busy), .ctl(ctl),
    .descInValid(descInValid), .descInData(descInData), .startReq(startReq),
    .fetchPending(fetchPending), .fifoEmpty(fifoEmpty), .headZero(headZero),
    .headLast(headLast), .head(head), .fetchSrc(fetchSrc), .fetchDst(fetchDst),
    .fetchLen(fetchLen), .wbAddr(wbAddr)
  );

  desc_fetch_fsm u_fsm (
    .clk(clk), .rstN(rstN), .startReq(startReq), .fetchPending(fetchPending),
    .fifoEmpty(fifoEmpty), .headZero(headZero), .headLast(headLast),
    .fetchReady(fetchReady), .moveReady(moveReady), .moveDone(moveDone),
    .wbReady(wbReady), .irqReady(irqReady), .busy(busy), .ctl(ctl),
    .fetchValid(fetchValid), .moveValid(moveValid), .wbValid(wbValid),
    .irqValid(irqValid)
  );

  assign moveSrc = head.srcAddr;
  assign moveDst = head.dstAddr;
  assign moveLen = head.lenDw;
  assign moveId  = head.descId;
  assign wbData  = 32'd1;
endmodule

// File: rtl/desc_fetch_chk.sv
module desc_fetch_chk (
  input logic        clk,
  input logic        rstN,
  input logic        busy,
  input logic        regWrEn,
  input logic [2:0]  regAddr,
  input logic        fetchValid,
  input logic        fetchReady,
  input logic [63:0] fetchSrc,
  input logic        moveValid,
  input logic        moveReady,
  input logic        moveDone,
  input logic [17:0] moveLen,
  input logic        wbValid,
  input logic        wbReady,
  input logic        irqValid
);
  logic inFlight;

  always_ff @(posedge clk) begin
    if (!rstN)                        inFlight <= 1'b0;
    else if (moveValid && moveReady)  inFlight <= 1'b1;
    else if (moveDone)                inFlight <= 1'b0;
  end

  a_r3_start_sets_busy: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == 3'd3 && !busy) |=> busy);
  a_r4_fetch_held: assert property (@(posedge clk) disable iff (!rstN)
    (fetchValid && !fetchReady) |=> (fetchValid && $stable(fetchSrc)));
  a_r7_single_flight: assert property (@(posedge clk) disable iff (!rstN)
    inFlight |-> !moveValid);
  a_r8_nonzero_len: assert property (@(posedge clk) disable iff (!rstN)
    moveValid |-> (moveLen != 18'd0));
  a_r9_wb_after_done: assert property (@(posedge clk) disable iff (!rstN)
    wbValid |-> (!inFlight && !moveValid && !fetchValid));
  a_r10_irq_after_wb: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqValid) |-> $past(wbValid && wbReady));
  a_r11_busy_write_kept: assert property (@(posedge clk) disable iff (!rstN)
    (busy && regWrEn && regAddr == 3'd3 && !(irqValid)) |=> busy);
endmodule

bind desc_fetch_ctrl desc_fetch_chk u_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .regWrEn(regWrEn), .regAddr(regAddr),
  .fetchValid(fetchValid), .fetchReady(fetchReady), .fetchSrc(fetchSrc),
  .moveValid(moveValid), .moveReady(moveReady), .moveDone(moveDone),
  .moveLen(moveLen), .wbValid(wbValid), .wbReady(wbReady), .irqValid(irqValid)
);

// File: tb/sim_desc_fetch_ctrl.sv
module sim_desc_fetch_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 4;
  localparam int DONE_DLY   = 6;

  typedef struct packed {
    logic [63:0] src;
    logic [63:0] dst;
    logic [17:0] len;
    logic [6:0]  id;
  } itemT;

  logic clk = 0, rstN = 0;
  logic regWrEn = 0;
  logic [2:0] regAddr = 0;
  logic [31:0] regWrData = 0, regRdData, wbData;
  logic fetchValid, fetchReady = 1, descInValid = 0, moveValid, moveReady = 1;
  logic moveDone = 0, wbValid, wbReady = 1, irqValid, irqReady = 1;
  logic [63:0] fetchSrc, moveSrc, moveDst, wbAddr;
  logic [31:0] fetchDst;
  logic [17:0] fetchLen, moveLen;
  logic [6:0]  moveId;
  logic [152:0] descInData = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  desc_fetch_ctrl #(.FIFO_DEPTH(DEPTH)) u0 (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .fetchValid(fetchValid),
    .fetchReady(fetchReady), .fetchSrc(fetchSrc), .fetchDst(fetchDst),
    .fetchLen(fetchLen), .descInValid(descInValid), .descInData(descInData),
    .moveValid(moveValid), .moveReady(moveReady), .moveSrc(moveSrc),
    .moveDst(moveDst), .moveLen(moveLen), .moveId(moveId), .moveDone(moveDone),
    .wbValid(wbValid), .wbReady(wbReady), .wbAddr(wbAddr), .wbData(wbData),
    .irqValid(irqValid), .irqReady(irqReady)
  );

  int nChecks = 0, nFails = 0;
  logic [17:0] lenTab [128];
  itemT expQ [$];
  int   rspQ [$];
  logic [63:0] tBase;
  logic [31:0] fBase;
  int curLast, nextFetch, consumed, maxAhead, doneTimer, flightId;
  bit inFlight, lastDoneSeen, wbSeen, irqSeen, checkAhead;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic itemT itemOf(input int id);
    itemT it;
    it.src = 64'hC000_0000_0000_0000 + (64'(id) << 16) + 64'(lenTab[id]);
    it.dst = 64'h0000_0000_0800_0000 + (64'(id) << 12);
    it.len = lenTab[id];
    it.id  = 7'(id);
    return it;
  endfunction

  task automatic regWrite(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 0;
  endtask

  task automatic regRead(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  // environment: read mover, data mover, upstream port; monitor side of the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      moveDone = 0;
      if (doneTimer > 0) begin
        doneTimer--;
        if (doneTimer == 0) begin
          moveDone = 1;
          if (flightId == curLast) lastDoneSeen = 1;
          inFlight = 0;
        end
      end else if (inFlight) begin
        chk(!moveValid, "R7", "offer while busy", 64'(moveValid), 0);
      end
      descInValid = 0;
      if (rspQ.size() > 0) begin
        descInValid = 1;
        descInData  = itemOf(rspQ.pop_front());
      end
      if (fetchValid) begin
        chk(nextFetch <= curLast, "R4", "extra fetch index", 64'(nextFetch), 64'(curLast));
        chk(fetchSrc == tBase + (64'(nextFetch) << 5), "R4", "fetchSrc",
            fetchSrc, tBase + (64'(nextFetch) << 5));
        chk(fetchDst == fBase + (32'(nextFetch) << 5), "R4", "fetchDst",
            64'(fetchDst), 64'(fBase + (32'(nextFetch) << 5)));
        chk(fetchLen == 18'd8, "R4", "fetchLen", 64'(fetchLen), 8);
        if (checkAhead) begin
          chk(nextFetch + 1 - consumed <= DEPTH, "R5", "fetched ahead",
              64'(nextFetch + 1 - consumed), DEPTH);
          if (nextFetch + 1 - consumed > maxAhead) maxAhead = nextFetch + 1 - consumed;
        end
        rspQ.push_back(nextFetch);
        nextFetch++;
      end
      if (moveValid) begin
        itemT got, exp;
        got = {moveSrc, moveDst, moveLen, moveId};
        if (expQ.size() == 0) begin
          chk(0, "R8", "unexpected dispatch id", 64'(moveId), 0);
        end else begin
          exp = expQ.pop_front();
          chk(got == exp, "R6", "dispatch src", got.src, exp.src);
          chk(got.id == exp.id && got.len == exp.len && got.dst == exp.dst,
              "R6", "dispatch id/len/dst", {got.id, got.len}, {exp.id, exp.len});
        end
        inFlight  = 1;
        flightId  = int'(moveId);
        doneTimer = DONE_DLY;
        consumed  = int'(moveId) + 1;
      end
      if (wbValid && !wbSeen) begin
        if (lenTab[curLast] != 0)
          chk(lastDoneSeen, "R9", "done write before final completion", 64'(lastDoneSeen), 1);
        else
          chk(expQ.size() == 0 && !inFlight, "R9", "done write early after skip",
              64'(expQ.size()), 0);
        chk(wbAddr == tBase + (64'(curLast) << 5) + 64'd24, "R9", "wbAddr",
            wbAddr, tBase + (64'(curLast) << 5) + 64'd24);
        chk(wbData == 32'd1, "R9", "wbData", 64'(wbData), 1);
        wbSeen = 1;
      end
      if (irqValid && !irqSeen) begin
        chk(wbSeen, "R10", "irq before done write", 64'(wbSeen), 1);
        irqSeen = 1;
      end
    end
  end

  // driver side of the scoreboard: one batch
  task automatic runJob(input int last, input logic [63:0] tb, input logic [31:0] fb,
                        input bit midWrite, input bit ahead);
    logic [31:0] rd;
    tBase = tb; fBase = fb; curLast = last;
    nextFetch = 0; consumed = 0; maxAhead = 0;
    lastDoneSeen = 0; wbSeen = 0; irqSeen = 0; checkAhead = ahead;
    for (int i = 0; i <= last; i++)
      if (lenTab[i] != 0) expQ.push_back(itemOf(i));
    regWrite(3'd0, tb[31:0]);
    regWrite(3'd1, tb[63:32]);
    regWrite(3'd2, fb);
    regWrite(3'd3, 32'(last));
    regRead(3'd4, rd);
    chk(rd[0] == 1'b1, "R3", "busy after start", 64'(rd), 1);
    if (midWrite) begin
      regWrite(3'd3, 32'(last + 4));
      regRead(3'd3, rd);
      chk(rd == 32'(last), "R11", "final index changed during run", 64'(rd), 64'(last));
    end
    while (!irqSeen) @(negedge clk);
    repeat (2) @(negedge clk);
    regRead(3'd4, rd);
    chk(rd[0] == 1'b0, "R10", "busy after interrupt", 64'(rd), 0);
    chk(nextFetch == last + 1, "R4", "fetch count", 64'(nextFetch), 64'(last + 1));
    if (midWrite)
      chk(nextFetch == last + 1, "R11", "fetch count after ignored write",
          64'(nextFetch), 64'(last + 1));
    chk(expQ.size() == 0, "R6", "undispatched descriptors", 64'(expQ.size()), 0);
    if (ahead) chk(maxAhead == DEPTH, "R5", "store limit reached", 64'(maxAhead), DEPTH);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFails++;
    $display("FAIL R10 watchdog: run never finished actual=hung expected=idle");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    doneTimer = 0; inFlight = 0; curLast = 0; tBase = 0; fBase = 0;
    wbSeen = 1; irqSeen = 1; checkAhead = 0; nextFetch = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    #1;
    chk(!fetchValid && !moveValid && !wbValid && !irqValid, "R1", "valids after reset",
        {fetchValid, moveValid, wbValid, irqValid}, 0);
    for (int a = 0; a < 5; a++) begin
      regRead(3'(a), rd);
      chk(rd == 0, "R1", "register after reset", 64'(rd), 0);
    end
    regWrite(3'd0, 32'hDEAD_BEE0);
    regWrite(3'd1, 32'h0000_00A5);
    regWrite(3'd2, 32'h0001_2340);
    regRead(3'd0, rd); chk(rd == 32'hDEAD_BEE0, "R2", "table base low", 64'(rd), 64'h DEADBEE0);
    regRead(3'd1, rd); chk(rd == 32'h0000_00A5, "R2", "table base high", 64'(rd), 64'hA5);
    regRead(3'd2, rd); chk(rd == 32'h0001_2340, "R2", "local base", 64'(rd), 64'h12340);

    for (int i = 0; i < 128; i++) lenTab[i] = 18'(16 + 3 * i);
    runJob(5, 64'h0000_0001_FFFF_FFE0, 32'h0008_0000, 1, 1);
    lenTab[0] = 18'd1;
    runJob(0, 64'h0000_0020_0000_0100, 32'h0000_4000, 0, 0);
    lenTab[0] = 18'd4; lenTab[1] = 18'd0; lenTab[2] = 18'd7; lenTab[3] = 18'd0;
    runJob(3, 64'h0000_0000_1000_0000, 32'h0000_8000, 0, 0);
    lenTab[1] = 18'd9; lenTab[3] = 18'd5;
    runJob(127, 64'h0000_0004_0000_0000, 32'h0010_0000, 0, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule